// File: doc/BRIEF.md
# Multicycle Processor Step Sequencer

This block is the control unit of a processor datapath in which a single memory port and a single ALU are reused across several clock cycles per instruction. It walks each instruction through a small set of steps (fetch, decode, then an opcode-specific tail of one to three more steps) and, in every step, drives the select and write-enable lines that tell the datapath which operands to route, which register or memory to write and how to update the program counter. Instructions therefore take three, four or five cycles.

The controller is a Moore machine: every control output is a function of the current step alone. The six-bit opcode, taken from the instruction register, is consulted only when the sequencer leaves the decode step or the address step. Five instruction kinds are recognised: register-register arithmetic, word load, word store, branch on equality and unconditional jump. Any other opcode ends the instruction right after decode, and the next cycle is a fresh fetch. A synchronous active-high reset puts the sequencer in the fetch step.

Top module: `mc_step_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle is a fetch step. This applies both after power-up and in the middle of an instruction.
- R2: A fetch step drives `mem_rd`=1, `ir_load`=1, `pc_load`=1, `alu_b_sel`=01, `alu_a_sel`=0, `alu_mode`=00, `pc_src_sel`=00 and `addr_from_alu`=0, with every other output at 0. The next step is always decode.
- R3: A decode step drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_mode`=00, with every other output at 0. It then branches on the opcode: arithmetic 000000 goes to execute, load 100011 and store 101011 go to address computation, branch 000100 goes to compare, and jump 000010 goes to the jump step.
- R4: A load takes 5 cycles. The address step drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00. The memory step drives `mem_rd`=1 and `addr_from_alu`=1. The write-back step drives `rf_wr`=1, `wb_from_mem`=1 and `rf_dst_sel`=0.
- R5: A store takes 4 cycles. After the same address step as a load, the store step drives `mem_wr`=1 and `addr_from_alu`=1, and the next cycle is a fetch. `mem_rd` and `mem_wr` are never high together.
- R6: An arithmetic instruction takes 4 cycles. The execute step drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10. The completion step drives `rf_wr`=1, `rf_dst_sel`=1 and `wb_from_mem`=0.
- R7: A branch takes 3 cycles. The compare step drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_load_if_zero`=1 and `pc_src_sel`=01, and the next cycle is a fetch. `pc_load` and `pc_load_if_zero` are never high together.
- R8: A jump takes 3 cycles. The jump step drives `pc_load`=1 and `pc_src_sel`=10, and the next cycle is a fetch.
- R9: Any opcode other than the five listed in R3, when seen in the decode step, makes the next cycle a fetch (2 cycles in total).
- R10: The opcode is examined only in the decode and address steps. Its value in the fetch, memory, write-back, execute, completion, compare and jump steps has no effect on outputs or sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_load | output | 1 | Unconditional program-counter write |
| pc_load_if_zero | output | 1 | Program-counter write qualified by ALU zero |
| addr_from_alu | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| wb_from_mem | output | 1 | Register write data from memory data register (1) or ALU result (0) |
| ir_load | output | 1 | Instruction register write enable |
| pc_src_sel | output | 2 | Next-PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU second operand: 00 B, 01 constant 4, 10 extended immediate, 11 shifted extended immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |

## Verification
In a fetch cycle the instruction read from the shared memory and the program-counter increment happen at the same time: `mem_rd`, `ir_load` and `pc_load` are all high while the ALU is set up for PC+4. The bench provokes this by issuing instructions back to back, so that every fetch directly follows a tail step that itself wrote the PC (jump, branch) or the memory (store). Each such cycle is compared as a complete output vector, so a missing or extra strobe in either the fetch or the step before it is reported. The checker also requires that the memory read and write strobes, and the two PC write strobes, are never high in the same cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int OP_W   = 6;
    localparam int STEP_W = 4;

    localparam logic [OP_W-1:0] OPC_ARITH = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

    typedef enum logic [STEP_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDMEM  = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STMEM  = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RWB    = 4'd7,
        ST_CMP    = 4'd8,
        ST_JUMP   = 4'd9
    } step_e;

    typedef enum logic [2:0] {
        K_ARITH, K_LOAD, K_STORE, K_BEQ, K_JUMP, K_NONE
    } kind_e;

    typedef struct packed {
        logic       pc_load;
        logic       pc_load_if_zero;
        logic       addr_from_alu;
        logic       mem_rd;
        logic       mem_wr;
        logic       wb_from_mem;
        logic       ir_load;
        logic [1:0] pc_src_sel;
        logic [1:0] alu_mode;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       rf_wr;
        logic       rf_dst_sel;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

    function automatic kind_e kind_of(input logic [OP_W-1:0] op);
        case (op)
            OPC_ARITH: return K_ARITH;
            OPC_LOAD:  return K_LOAD;
            OPC_STORE: return K_STORE;
            OPC_BEQ:   return K_BEQ;
            OPC_JUMP:  return K_JUMP;
            default:   return K_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_of(input step_e st);
        ctrl_t c;
        c = CTRL_IDLE;
        case (st)
            ST_FETCH: begin
                c.mem_rd    = 1'b1;
                c.ir_load   = 1'b1;
                c.pc_load   = 1'b1;
                c.alu_b_sel = 2'b01;
            end
            ST_DECODE: c.alu_b_sel = 2'b11;
            ST_ADDR: begin
                c.alu_a_sel = 1'b1;
                c.alu_b_sel = 2'b10;
            end
            ST_LDMEM: begin
                c.mem_rd        = 1'b1;
                c.addr_from_alu = 1'b1;
            end
            ST_LDWB: begin
                c.rf_wr       = 1'b1;
                c.wb_from_mem = 1'b1;
            end
            ST_STMEM: begin
                c.mem_wr        = 1'b1;
                c.addr_from_alu = 1'b1;
            end
            ST_EXEC: begin
                c.alu_a_sel = 1'b1;
                c.alu_mode  = 2'b10;
            end
            ST_RWB: begin
                c.rf_wr      = 1'b1;
                c.rf_dst_sel = 1'b1;
            end
            ST_CMP: begin
                c.alu_a_sel       = 1'b1;
                c.alu_mode        = 2'b01;
                c.pc_load_if_zero = 1'b1;
                c.pc_src_sel      = 2'b01;
            end
            ST_JUMP: begin
                c.pc_load    = 1'b1;
                c.pc_src_sel = 2'b10;
            end
            default: c = CTRL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mcs_classify.sv
module mcs_classify
    import mcs_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic [W-1:0] op,
    output kind_e        kind
);
    always_comb kind = kind_of(op);
endmodule

// File: rtl/mcs_next.sv
module mcs_next
    import mcs_pkg::*;
(
    input  step_e cur,
    input  kind_e kind,
    output step_e nxt
);
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                case (kind)
                    K_ARITH:          nxt = ST_EXEC;
                    K_LOAD, K_STORE:  nxt = ST_ADDR;
                    K_BEQ:            nxt = ST_CMP;
                    K_JUMP:           nxt = ST_JUMP;
                    default:          nxt = ST_FETCH;
                endcase
            end
            ST_ADDR: begin
                case (kind)
                    K_LOAD:  nxt = ST_LDMEM;
                    K_STORE: nxt = ST_STMEM;
                    default: nxt = ST_FETCH;
                endcase
            end
            ST_LDMEM: nxt = ST_LDWB;
            ST_EXEC:  nxt = ST_RWB;
            default:  nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcs_outdec.sv
module mcs_outdec
    import mcs_pkg::*;
(
    input  step_e cur,
    output ctrl_t ctl
);
    always_comb ctl = ctrl_of(cur);
endmodule

// File: rtl/mc_step_seq.sv
module mc_step_seq
    import mcs_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    output logic           pc_load,
    output logic           pc_load_if_zero,
    output logic           addr_from_alu,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           wb_from_mem,
    output logic           ir_load,
    output logic [1:0]     pc_src_sel,
    output logic [1:0]     alu_mode,
    output logic           alu_a_sel,
    output logic [1:0]     alu_b_sel,
    output logic           rf_wr,
    output logic           rf_dst_sel
);
    step_e cur_q;
    step_e nxt;
    kind_e kind;
    ctrl_t ctl;

    mcs_classify #(.W(OPW)) u_cls (.op(opcode), .kind(kind));
    mcs_next                u_nxt (.cur(cur_q), .kind(kind), .nxt(nxt));
    mcs_outdec              u_dec (.cur(cur_q), .ctl(ctl));

    always_ff @(posedge clk) begin
        if (rst) cur_q <= ST_FETCH;
        else     cur_q <= nxt;
    end

    assign pc_load         = ctl.pc_load;
    assign pc_load_if_zero = ctl.pc_load_if_zero;
    assign addr_from_alu   = ctl.addr_from_alu;
    assign mem_rd          = ctl.mem_rd;
    assign mem_wr          = ctl.mem_wr;
    assign wb_from_mem     = ctl.wb_from_mem;
    assign ir_load         = ctl.ir_load;
    assign pc_src_sel      = ctl.pc_src_sel;
    assign alu_mode        = ctl.alu_mode;
    assign alu_a_sel       = ctl.alu_a_sel;
    assign alu_b_sel       = ctl.alu_b_sel;
    assign rf_wr           = ctl.rf_wr;
    assign rf_dst_sel      = ctl.rf_dst_sel;
endmodule

// File: rtl/mc_step_seq_chk.sv
module mc_step_seq_chk
    import mcs_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] opcode,
    input logic           pc_load,
    input logic           pc_load_if_zero,
    input logic           addr_from_alu,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           wb_from_mem,
    input logic           ir_load,
    input logic [1:0]     pc_src_sel,
    input logic [1:0]     alu_mode,
    input logic           alu_a_sel,
    input logic [1:0]     alu_b_sel,
    input logic           rf_wr,
    input logic           rf_dst_sel
);
    logic in_decode;
    logic op_known;
    assign in_decode = (alu_b_sel == 2'b11);
    assign op_known  = (opcode == OPC_ARITH) || (opcode == OPC_LOAD) ||
                       (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
                       (opcode == OPC_JUMP);

    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (ir_load && mem_rd && pc_load));

    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (in_decode && !ir_load && !mem_rd));

    p_decode_load_r3: assert property (@(posedge clk) disable iff (rst)
        (in_decode && opcode == OPC_LOAD) |=> (alu_a_sel && alu_b_sel == 2'b10));

    p_load_wb_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_from_alu) |=> (rf_wr && wb_from_mem && !rf_dst_sel));

    p_mem_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_store_end_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_load);

    p_arith_wb_r6: assert property (@(posedge clk) disable iff (rst)
        (alu_mode == 2'b10) |=> (rf_wr && rf_dst_sel && !wb_from_mem));

    p_pc_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(pc_load && pc_load_if_zero));

    p_branch_end_r7: assert property (@(posedge clk) disable iff (rst)
        pc_load_if_zero |=> ir_load);

    p_jump_end_r8: assert property (@(posedge clk) disable iff (rst)
        (pc_load && pc_src_sel == 2'b10) |=> ir_load);

    p_unknown_op_r9: assert property (@(posedge clk) disable iff (rst)
        (in_decode && !op_known) |=> ir_load);
endmodule

bind mc_step_seq mc_step_seq_chk #(.OPW(OPW)) u_chk (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_from_mem(wb_from_mem), .ir_load(ir_load), .pc_src_sel(pc_src_sel),
    .alu_mode(alu_mode), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel)
);

// File: tb/mc_step_seq_bench.sv
`timescale 1ns/1ps
module mc_step_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b000000;
    logic       pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr;
    logic       wb_from_mem, ir_load, alu_a_sel, rf_wr, rf_dst_sel;
    logic [1:0] pc_src_sel, alu_mode, alu_b_sel;

    always #2 clk = ~clk;

    mc_step_seq u_mc_step_seq (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
        .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_from_mem(wb_from_mem), .ir_load(ir_load), .pc_src_sel(pc_src_sel),
        .alu_mode(alu_mode), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel)
    );

    // Vector order: pcld pcz iord mrd mwr m2r irld pcsrc[2] aop[2] asa asb[2] rfw dst
    logic [15:0] got;
    assign got = {pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr,
                  wb_from_mem, ir_load, pc_src_sel, alu_mode, alu_a_sel,
                  alu_b_sel, rf_wr, rf_dst_sel};

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_on   = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    function automatic logic [15:0] mk(input logic pcl, pcz, ia, mr, mw, wm, il,
                                       input logic [1:0] ps, am,
                                       input logic aa, input logic [1:0] ab,
                                       input logic rw, rd);
        return {pcl, pcz, ia, mr, mw, wm, il, ps, am, aa, ab, rw, rd};
    endfunction

    // Step labels used only by this bench: 0 fetch,1 decode,2 address,3 load mem,
    // 4 load wb,5 store,6 execute,7 arith wb,8 compare,9 jump
    function automatic logic [15:0] exp_vec(input int s);
        case (s)
            0: return mk(1,0,0,1,0,0,1,2'b00,2'b00,0,2'b01,0,0);
            1: return mk(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0);
            2: return mk(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0);
            3: return mk(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0);
            4: return mk(0,0,0,0,0,1,0,2'b00,2'b00,0,2'b00,1,0);
            5: return mk(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0);
            6: return mk(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0);
            7: return mk(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1);
            8: return mk(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0);
            9: return mk(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0);
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(input int s);
        case (s)
            0: return "R2 fetch";
            1: return "R3 decode";
            2, 3, 4: return "R4 load";
            5: return "R5 store";
            6, 7: return "R6 arith";
            8: return "R7 branch";
            9: return "R8 jump";
            default: return "?";
        endcase
    endfunction

    task automatic chk(input logic [15:0] g, input logic [15:0] e, input string tag);
        n_checks++;
        if (g !== e) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, g, e);
        end
    endtask

    // Driver: pushes the expected per-cycle vectors, then drives the opcode.
    // The opcode is the real one only in cycles 1 and 2; 'late' elsewhere.
    task automatic run_instr(input logic [5:0] op, input logic [5:0] late,
                             input string pre);
        int steps[$];
        steps.push_back(0);
        steps.push_back(1);
        case (op)
            6'b100011: begin steps.push_back(2); steps.push_back(3); steps.push_back(4); end
            6'b101011: begin steps.push_back(2); steps.push_back(5); end
            6'b000000: begin steps.push_back(6); steps.push_back(7); end
            6'b000100: steps.push_back(8);
            6'b000010: steps.push_back(9);
            default: ;
        endcase
        foreach (steps[i]) begin
            exp_q.push_back(exp_vec(steps[i]));
            tag_q.push_back({pre, req_of(steps[i])});
        end
        for (int c = 0; c < steps.size(); c++) begin
            opcode = (c == 1 || c == 2) ? op : late;
            @(negedge clk);
        end
    endtask

    // Monitor: pops one expectation per cycle, sampled mid-phase.
    always @(negedge clk) begin
        #1;
        if (mon_on && exp_q.size() > 0) begin
            chk(got, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(got, exp_vec(0), "R1 reset state");
        @(negedge clk);
        rst    = 1'b0;
        mon_on = 1'b1;

        run_instr(6'b100011, 6'b100011, "");          // load
        run_instr(6'b101011, 6'b101011, "");          // store
        run_instr(6'b000000, 6'b000000, "");          // arithmetic
        run_instr(6'b000100, 6'b000100, "");          // branch
        run_instr(6'b000010, 6'b000010, "");          // jump
        run_instr(6'b111111, 6'b000000, "R9 ");       // unknown
        run_instr(6'b000010, 6'b000100, "R9 ");       // fetch after unknown
        run_instr(6'b000001, 6'b100011, "R9 ");       // another unknown
        run_instr(6'b101010, 6'b101011, "R9 ");       // near-miss of store
        // R10: opcode swapped outside decode/address steps
        run_instr(6'b100011, 6'b101011, "R10 ");
        run_instr(6'b101011, 6'b100011, "R10 ");
        run_instr(6'b000000, 6'b000010, "R10 ");
        run_instr(6'b000100, 6'b111111, "R10 ");
        run_instr(6'b000010, 6'b000100, "R10 ");
        // back-to-back write strobes around fetch
        run_instr(6'b101011, 6'b000000, "");
        run_instr(6'b000010, 6'b000000, "");
        run_instr(6'b000100, 6'b000000, "");
        run_instr(6'b100011, 6'b000000, "");

        // R1: reset in the middle of an arithmetic instruction
        mon_on = 1'b0;
        opcode = 6'b000000;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(got, exp_vec(6), "R6 exec before reset");
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk(got, exp_vec(0), "R1 mid-instruction reset");
        @(negedge clk);
        rst    = 1'b0;
        mon_on = 1'b1;
        run_instr(6'b000100, 6'b000100, "R1 after reset ");

        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule